// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms

This block keeps wall-clock time in a watch style. A slow clock enable of nominally 32.768 kHz is divided down to a one-second tick. That tick advances a chain of counters: seconds, minutes, hours and a day-of-year count that runs from 0 to 364. Each rollover can raise a periodic interrupt. Two alarm comparators watch the live time. The first matches on hour, minute and second and ignores the day. The second also needs the day count to match. A stopwatch counts down once per minute and interrupts when it runs out.

Software reaches the block through a simple register port with a write strobe, an address and write data. Read data is combinational from the address. Every event latches into a sticky status bit, and software clears a bit by writing 1 to it. The interrupt output is the OR of the status bits that are enabled. The wakeup output is a single-cycle pulse whenever an enabled event is latched.

Register map (3-bit address): 0 time, 1 time-of-day alarm, 2 day-and-time alarm, 3 stopwatch count (bits 15:0), 4 interrupt enable, 5 status, 6 control (bit 0 = stopwatch run). The time and alarm words share one layout: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16, day in bits 31:23. The event bits in the enable and status registers are: 0 second, 1 minute, 2 hour, 3 day, 4 time-of-day alarm, 5 day-and-time alarm, 6 stopwatch underflow.

Top module: `rtc_calendar`

## Requirements
- R1: The seconds field advances exactly once for every PRESCALE cycles in which clk_en is high. With no time write in between, it never advances before the PRESCALE-th enabled cycle.
- R2: Seconds and minutes count 0 to 59 and hours count 0 to 23. Each field wraps to 0 and carries one into the next field.
- R3: The day count runs 0 to 364. When the time rolls from 23:59:59 on day 364, the day becomes 0.
- R4: A write to address 0 loads all four time fields and restarts the prescaler. The next second tick then needs a full PRESCALE enabled cycles.
- R5: Status bit 0 sets on every second tick. Bit 1 sets when seconds wrap, bit 2 when minutes wrap, and bit 3 when hours wrap.
- R6: Status bit 4 sets on the tick at which the new hour, minute and second equal the time-of-day alarm, on any day.
- R7: Status bit 5 sets on the tick at which the new day, hour, minute and second all equal the day-and-time alarm. It does not set when only the day differs.
- R8: Status bits latch whether or not they are enabled. The irq output is high exactly when some status bit and the same enable bit are both 1.
- R9: While run is 1, each minute rollover lowers a nonzero stopwatch count by one. A minute rollover with the count at 0 sets status bit 6, keeps the count at 0 and clears run.
- R10: Writing to address 5 clears every status bit whose data bit is 1 and leaves the others unchanged.
- R11: wake is a one-cycle pulse, raised in the cycle after an edge at which an event whose enable bit is 1 is latched. It is low otherwise.
- R12: After reset, time, alarms, stopwatch, enables, status and run are 0, and irq and wake are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Slow time-base enable (32.768 kHz rate) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | OR of enabled status bits |
| wake | output | 1 | One-cycle wakeup pulse on an enabled event |

## Verification
A prescaler count that is off by one shows up within one second tick. The seconds field moves early or late, and the bench samples that field on the enabled cycles just before and just after the expected tick. A carry-chain fault, such as a wrong limit or a missed wrap, shows as a wrong time word or a missing rollover status bit at the first boundary crossed. The bench reaches those boundaries within a few ticks by loading times just below them. A bad alarm compare or a bad stopwatch state appears as a wrong status bit, irq level or wake pulse at the tick where the match or the underflow should occur. wake is compared on every stepped cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [8:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    localparam int unsigned EV_SEC   = 0;
    localparam int unsigned EV_MIN   = 1;
    localparam int unsigned EV_HOUR  = 2;
    localparam int unsigned EV_DAY   = 3;
    localparam int unsigned EV_ALA   = 4;
    localparam int unsigned EV_ALB   = 5;
    localparam int unsigned EV_SW    = 6;
    localparam int unsigned EV_COUNT = 7;

    typedef enum logic [2:0] {
        A_TIME   = 3'd0,
        A_ALARMA = 3'd1,
        A_ALARMB = 3'd2,
        A_SWCNT  = 3'd3,
        A_IRQEN  = 3'd4,
        A_STATUS = 3'd5,
        A_CTRL   = 3'd6
    } rtc_addr_e;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [8:0] DAY_LAST  = 9'd364;

    function automatic logic [31:0] time_to_word(rtc_time_t t);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = t.sec;
        w[13:8]  = t.min;
        w[20:16] = t.hour;
        w[31:23] = t.day;
        return w;
    endfunction

    function automatic rtc_time_t word_to_time(logic [31:0] w);
        rtc_time_t t;
        t.sec  = w[5:0];
        t.min  = w[13:8];
        t.hour = w[20:16];
        t.day  = w[31:23];
        return t;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic restart,
    output logic sec_tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (clk_en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assign sec_tick = clk_en && !restart && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R1: two ticks are never back to back when the divider exceeds one
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                sec_tick |=> !sec_tick);
        end
    endgenerate
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t time_q,
    output rtc_time_t time_nxt,
    output logic      sec_ev,
    output logic      min_ev,
    output logic      hour_ev,
    output logic      day_ev
);
    logic adv;
    logic sec_wrap, min_wrap, hour_wrap;

    assign adv = tick && !load;

    always_comb begin
        time_nxt  = time_q;
        sec_wrap  = time_q.sec  >= SEC_LAST;
        min_wrap  = sec_wrap && (time_q.min >= MIN_LAST);
        hour_wrap = min_wrap && (time_q.hour >= HOUR_LAST);
        if (sec_wrap) time_nxt.sec = '0;
        else          time_nxt.sec = time_q.sec + 6'd1;
        if (sec_wrap) begin
            if (min_wrap) time_nxt.min = '0;
            else          time_nxt.min = time_q.min + 6'd1;
        end
        if (min_wrap) begin
            if (hour_wrap) time_nxt.hour = '0;
            else           time_nxt.hour = time_q.hour + 5'd1;
        end
        if (hour_wrap) begin
            if (time_q.day >= DAY_LAST) time_nxt.day = '0;
            else                        time_nxt.day = time_q.day + 9'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       time_q <= '0;
        else if (load) time_q <= load_val;
        else if (adv)  time_q <= time_nxt;
    end

    assign sec_ev  = adv;
    assign min_ev  = adv && sec_wrap;
    assign hour_ev = adv && min_wrap;
    assign day_ev  = adv && hour_wrap;

    // R2: time holds between ticks and writes
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(time_q));
    // R2: seconds wrap from 59
    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && time_q.sec == 6'd59) |=> (time_q.sec == 6'd0));
    // R3: day wraps from 364 at the end of the last day
    a_r3_day_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && time_q.day == 9'd364 && time_q.hour == 5'd23 &&
         time_q.min == 6'd59 && time_q.sec == 6'd59) |=> (time_q.day == 9'd0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
#(
    parameter bit USE_DAY = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  rtc_time_t wval,
    input  logic      tick,
    input  rtc_time_t cand,
    output rtc_time_t alarm_q,
    output logic      hit
);
    logic tod_eq, day_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
        end else if (wr) begin
            alarm_q     <= wval;
            if (!USE_DAY) alarm_q.day <= '0;
        end
    end

    assign tod_eq = (cand.hour == alarm_q.hour) && (cand.min == alarm_q.min) &&
                    (cand.sec == alarm_q.sec);

    generate
        if (USE_DAY) begin : g_day
            assign day_eq = (cand.day == alarm_q.day);
        end else begin : g_tod
            assign day_eq = 1'b1;
        end
    endgenerate

    assign hit = tick && tod_eq && day_eq;
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
    parameter int unsigned SW_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_wr,
    input  logic [SW_W-1:0] cnt_val,
    input  logic            run_wr,
    input  logic            run_val,
    input  logic            min_ev,
    output logic [SW_W-1:0] count_q,
    output logic            run_q,
    output logic            under
);
    assign under = min_ev && run_q && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            if (cnt_wr)
                count_q <= cnt_val;
            else if (min_ev && run_q && count_q != '0)
                count_q <= count_q - 1'b1;
            if (run_wr)     run_q <= run_val;
            else if (under) run_q <= 1'b0;
        end
    end

    // R9: underflow stops the stopwatch and leaves it at zero
    a_r9_underflow_stops: assert property (@(posedge clk) disable iff (rst)
        (under && !cnt_wr && !run_wr) |=> (!run_q && count_q == '0));
    // R9: a stopped stopwatch keeps its count unless written
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_wr) |=> $stable(count_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int unsigned PRESCALE = 32768,
    parameter int unsigned SW_W     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_en,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        wake
);
    localparam int unsigned NA = 2;

    logic      wr_time, wr_swc, wr_en, wr_st, wr_ctrl;
    logic      sec_tick;
    rtc_time_t time_q, time_nxt;
    logic      sec_ev, min_ev, hour_ev, day_ev;
    logic [NA-1:0] al_wr, al_hit;
    rtc_time_t al_q [NA];
    logic [SW_W-1:0] sw_count;
    logic      sw_run, sw_under;
    logic [EV_COUNT-1:0] ev, irq_en, status;

    assign wr_time = reg_wr && (reg_addr == A_TIME);
    assign wr_swc  = reg_wr && (reg_addr == A_SWCNT);
    assign wr_en   = reg_wr && (reg_addr == A_IRQEN);
    assign wr_st   = reg_wr && (reg_addr == A_STATUS);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign al_wr[0] = reg_wr && (reg_addr == A_ALARMA);
    assign al_wr[1] = reg_wr && (reg_addr == A_ALARMB);

    rtc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .clk_en(clk_en), .restart(wr_time), .sec_tick(sec_tick)
    );

    rtc_time_counter u_cnt (
        .clk(clk), .rst(rst), .tick(sec_tick), .load(wr_time),
        .load_val(word_to_time(reg_wdata)), .time_q(time_q), .time_nxt(time_nxt),
        .sec_ev(sec_ev), .min_ev(min_ev), .hour_ev(hour_ev), .day_ev(day_ev)
    );

    generate
        for (genvar i = 0; i < NA; i++) begin : g_alarm
            rtc_alarm #(.USE_DAY(i == 1)) u_al (
                .clk(clk), .rst(rst), .wr(al_wr[i]), .wval(word_to_time(reg_wdata)),
                .tick(sec_ev), .cand(time_nxt), .alarm_q(al_q[i]), .hit(al_hit[i])
            );
        end
    endgenerate

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk(clk), .rst(rst), .cnt_wr(wr_swc), .cnt_val(reg_wdata[SW_W-1:0]),
        .run_wr(wr_ctrl), .run_val(reg_wdata[0]), .min_ev(min_ev),
        .count_q(sw_count), .run_q(sw_run), .under(sw_under)
    );

    always_comb begin
        ev          = '0;
        ev[EV_SEC]  = sec_ev;
        ev[EV_MIN]  = min_ev;
        ev[EV_HOUR] = hour_ev;
        ev[EV_DAY]  = day_ev;
        ev[EV_ALA]  = al_hit[0];
        ev[EV_ALB]  = al_hit[1];
        ev[EV_SW]   = sw_under;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= '0;
            status <= '0;
            wake   <= 1'b0;
        end else begin
            if (wr_en) irq_en <= reg_wdata[EV_COUNT-1:0];
            if (wr_st) status <= (status & ~reg_wdata[EV_COUNT-1:0]) | ev;
            else       status <= status | ev;
            wake <= |(ev & irq_en);
        end
    end

    assign irq = |(status & irq_en);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_TIME:   reg_rdata = time_to_word(time_q);
            A_ALARMA: reg_rdata = time_to_word(al_q[0]);
            A_ALARMB: reg_rdata = time_to_word(al_q[1]);
            A_SWCNT:  reg_rdata[SW_W-1:0] = sw_count;
            A_IRQEN:  reg_rdata[EV_COUNT-1:0] = irq_en;
            A_STATUS: reg_rdata[EV_COUNT-1:0] = status;
            A_CTRL:   reg_rdata[0] = sw_run;
            default:  reg_rdata = '0;
        endcase
    end

    // R10: status bits only fall through a clearing write
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr_st |=> ((status & $past(status)) == $past(status)));
    // R5: a second tick always lands in status bit 0
    a_r5_sec_status: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> status[EV_SEC]);
    // R11: wake only follows an edge that latched some event
    a_r11_wake_cause: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(ev) != '0);
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, wake;

    int checks = 0;
    int errors = 0;

    // bench model
    int m_sec, m_min, m_hr, m_day, m_pc;
    int a_sec, a_min, a_hr;
    int b_sec, b_min, b_hr, b_day;
    int m_sw;
    bit m_run;
    bit [6:0] m_en, m_st;
    bit exp_wake;

    always #2.5 clk = ~clk;

    rtc_calendar #(.PRESCALE(P), .SW_W(16)) uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .wake(wake)
    );

    initial begin
        #2_000_000;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [31:0] pack(int s, int mi, int h, int d);
        logic [31:0] w;
        w = '0;
        w[5:0] = 6'(s); w[13:8] = 6'(mi); w[20:16] = 5'(h); w[31:23] = 9'(d);
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_tick();
        bit [6:0] ev;
        ev = 7'b1;
        if (m_sec >= 59) begin
            m_sec = 0; ev[1] = 1;
            if (m_min >= 59) begin
                m_min = 0; ev[2] = 1;
                if (m_hr >= 23) begin
                    m_hr = 0; ev[3] = 1;
                    m_day = (m_day >= 364) ? 0 : m_day + 1;
                end else m_hr++;
            end else m_min++;
        end else m_sec++;
        if (m_sec == a_sec && m_min == a_min && m_hr == a_hr) ev[4] = 1;
        if (m_sec == b_sec && m_min == b_min && m_hr == b_hr && m_day == b_day) ev[5] = 1;
        if (ev[1] && m_run) begin
            if (m_sw == 0) begin ev[6] = 1; m_run = 0; end
            else m_sw--;
        end
        m_st |= ev;
        exp_wake = |(ev & m_en);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) chk("R11 wake", {31'b0, wake}, {31'b0, exp_wake});
            clk_en = 1'b1;
            exp_wake = 1'b0;
            if (m_pc == P - 1) begin m_pc = 0; model_tick(); end
            else m_pc++;
        end
        @(negedge clk);
        clk_en = 1'b0;
        chk("R11 wake", {31'b0, wake}, {31'b0, exp_wake});
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        case (a)
            3'd0: begin m_sec = d[5:0]; m_min = d[13:8]; m_hr = d[20:16]; m_day = d[31:23]; m_pc = 0; end
            3'd1: begin a_sec = d[5:0]; a_min = d[13:8]; a_hr = d[20:16]; end
            3'd2: begin b_sec = d[5:0]; b_min = d[13:8]; b_hr = d[20:16]; b_day = d[31:23]; end
            3'd3: m_sw = d[15:0];
            3'd4: m_en = d[6:0];
            3'd5: m_st &= ~d[6:0];
            3'd6: m_run = d[0];
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        rd(3'd0, v); chk({req, " time"}, v, pack(m_sec, m_min, m_hr, m_day));
        rd(3'd5, v); chk({req, " status"}, v, {25'b0, m_st});
        rd(3'd3, v); chk({req, " stopwatch"}, v, 32'(m_sw));
        rd(3'd6, v); chk({req, " run"}, v, {31'b0, m_run});
        chk({req, " irq"}, {31'b0, irq}, {31'b0, |(m_st & m_en)});
    endtask

    initial begin
        logic [31:0] v;
        int seed;
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_pc = 0;
        a_sec = 0; a_min = 0; a_hr = 0; b_sec = 0; b_min = 0; b_hr = 0; b_day = 0;
        m_sw = 0; m_run = 0; m_en = 0; m_st = 0; exp_wake = 0;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state (alarms at zero: the bench never steps into 00:00:00 without reloading them)
        check_all("R12");
        rd(3'd1, v); chk("R12 alarmA", v, 32'd0);
        chk("R12 wake", {31'b0, wake}, 32'd0);
        // move alarms away from reachable values for now
        wr(3'd1, pack(33, 33, 13, 0));
        wr(3'd2, pack(33, 33, 13, 200));
        // R1 prescaler
        step(P - 1);
        check_all("R1 before tick");
        step(1);
        check_all("R1 first tick R5");
        // R2/R3 full rollover from end of year
        wr(3'd4, 32'h0f);
        wr(3'd5, 32'h7f);
        wr(3'd0, pack(58, 59, 23, 364));
        step(2 * P);
        check_all("R3 day wrap R2 R5");
        // R4 write restarts prescaler
        step(2);
        wr(3'd0, pack(10, 20, 5, 100));
        step(P - 1);
        check_all("R4 no early tick");
        step(1);
        check_all("R4 tick after full second");
        // R6 time-of-day alarm, any day
        wr(3'd5, 32'h7f);
        wr(3'd1, pack(0, 1, 0, 0));
        wr(3'd4, 32'h10);
        wr(3'd0, pack(58, 0, 0, 5));
        step(2 * P);
        check_all("R6 alarm A hit R8");
        // R7 day-and-time alarm: wrong day misses, right day hits
        wr(3'd5, 32'h7f);
        wr(3'd4, 32'h20);
        wr(3'd2, pack(0, 0, 1, 7));
        wr(3'd0, pack(59, 59, 0, 6));
        step(P);
        check_all("R7 day mismatch");
        wr(3'd0, pack(59, 59, 0, 7));
        step(P);
        check_all("R7 day match");
        // R8 disabled event latches without irq
        wr(3'd5, 32'h7f);
        wr(3'd4, 32'h00);
        step(P);
        check_all("R8 disabled");
        wr(3'd4, 32'h01);
        check_all("R8 enable after latch");
        // R10 partial clear
        wr(3'd5, 32'h01);
        check_all("R10 clear bit0");
        // R9 stopwatch
        wr(3'd5, 32'h7f);
        wr(3'd4, 32'h40);
        wr(3'd3, 32'd1);
        wr(3'd6, 32'd1);
        wr(3'd0, pack(59, 10, 2, 3));
        step(P);
        check_all("R9 decrement");
        step(60 * P);
        check_all("R9 underflow");
        step(60 * P);
        check_all("R9 stays stopped");
        wr(3'd5, 32'h40);
        check_all("R10 clear underflow");
        // random phase
        for (int k = 0; k < 25; k++) begin
            wr(3'd4, 32'($urandom % 128));
            wr(3'd5, 32'($urandom % 128));
            if ($urandom % 2) wr(3'd3, 32'($urandom % 3));
            if ($urandom % 2) wr(3'd6, 32'($urandom % 2));
            wr(3'd1, pack($urandom % 60, $urandom % 60, $urandom % 24, 0));
            wr(3'd0, pack(55 + $urandom % 5, 57 + $urandom % 3, 22 + $urandom % 2,
                          362 + $urandom % 3));
            step(1 + $urandom % (8 * P));
            check_all("R2 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule